// File: doc/BRIEF.md
# Transmit Timeout Guard

A small guard that sits beside a half-duplex modem and keeps it from staying in transmit indefinitely. Software chooses the direction by writing a one-bit mode register: 1 puts the modem in transmit, 0 in receive. While the modem transmits, a down-counter loses one count on every pulse of a prescaled tick input. If it runs out, the guard clears the mode bit itself and raises a sticky timeout flag.

A long transmission stays alive only if software writes one specific key byte to a service register before the counter runs out. The write reloads the counter to full scale. Any other byte written to that register is discarded. The flag remains set until software writes to a clear register. The block has a plain write port (address, data, strobe) and two outputs: the current mode and the timeout flag.

Top module: `txmode_guard`

## Requirements
- R1: After reset the mode output is 0 (receive), the timeout flag is 0 and the counter holds full scale, 2^CNT_W-1 (8191 at the default CNT_W of 13).
- R2: A write to address 0 sets the mode to bit 0 of the data (1 = transmit, 0 = receive) on the next clock. Writing 0 ends transmit at once.
- R3: A write of 1 to address 0 while in receive reloads the counter to 2^CNT_W-1. A write of 1 while already in transmit leaves the count untouched.
- R4: In transmit, each tick lowers the count by one. When the count reaches 0, the mode goes to 0 on the clock edge that takes that tick, which is exactly 2^CNT_W-1 ticks after the last reload.
- R5: In receive, ticks leave the count, the mode and the flag unchanged.
- R6: Writing the key 0xA2 to address 1 reloads the counter to 2^CNT_W-1 without changing the mode.
- R7: Writing any value other than 0xA2 to address 1 has no effect on the count, the mode or the flag.
- R8: A forced return to receive sets the timeout flag, which stays set until any write to address 2. If a clear and a forced return fall in the same cycle, the flag ends up set.
- R9: A tick in the same cycle as a write to address 0 or a key write is discarded. A key write that arrives with the final tick therefore prevents the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count-enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address: 0 mode, 1 key, 2 flag clear |
| wr_data_i | input | DATA_W | Write data |
| tx_mode_o | output | 1 | 1 = transmit, 0 = receive |
| timeout_o | output | 1 | Sticky forced-return flag |

## Verification
Two pairs of events can fall in the same cycle. In the first, the final tick arrives together with a key write; the bench drives both in one cycle and expects transmit to continue for another full 2^CNT_W-1 ticks. In the second, a forced return coincides with a write to the clear address; the bench expects the flag to read 1 afterwards. The bench uses CNT_W = 4, so every kick position and every non-key data byte can be swept, and it compares the number of ticks until the drop against arithmetic on the reload value.

// File: rtl/txg_pkg.sv
package txg_pkg;
  typedef struct packed {
    logic mode_wr;
    logic mode_val;
    logic kick;
    logic stat_clr;
  } txg_wr_t;
endpackage

// File: rtl/txg_dec.sv
module txg_dec import txg_pkg::*; #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hA2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 0,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 1,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 2
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output txg_wr_t           wr_o
);
  always_comb begin
    wr_o.mode_wr  = wr_en_i && (wr_addr_i == MODE_ADDR);
    wr_o.mode_val = wr_data_i[0];
    wr_o.kick     = wr_en_i && (wr_addr_i == KICK_ADDR) && (wr_data_i == KEY);
    wr_o.stat_clr = wr_en_i && (wr_addr_i == CLR_ADDR);
  end
endmodule

// File: rtl/txg_cnt.sv
module txg_cnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= FULL;
    else if (load_i)                  cnt_q <= FULL;
    else if (step_i && cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/txg_ctl.sv
module txg_ctl import txg_pkg::*; (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  txg_wr_t wr_i,
  input  logic    expire_i,
  output logic    mode_o,
  output logic    flag_o,
  output logic    entry_o
);
  logic mode_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mode_q <= 1'b0;
    else if (wr_i.mode_wr) mode_q <= wr_i.mode_val;
    else if (expire_i)    mode_q <= 1'b0;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_q <= 1'b0;
    else if (expire_i)      flag_q <= 1'b1;
    else if (wr_i.stat_clr) flag_q <= 1'b0;
  end

  assign entry_o = wr_i.mode_wr && wr_i.mode_val && !mode_q;
  assign mode_o  = mode_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/txmode_guard.sv
module txmode_guard import txg_pkg::*; #(
  parameter int CNT_W  = 13,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hA2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 0,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 1,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_mode_o,
  output logic              timeout_o
);
  txg_wr_t          wr;
  logic             entry, load, step, last, expire;
  logic [CNT_W-1:0] cnt_w;

  txg_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY),
    .MODE_ADDR(MODE_ADDR), .KICK_ADDR(KICK_ADDR), .CLR_ADDR(CLR_ADDR)
  ) dec_i (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wr_o(wr)
  );

  // writes take precedence: a coinciding tick is dropped
  assign load   = wr.kick || entry;
  assign step   = tick_i && tx_mode_o && !wr.kick && !wr.mode_wr;
  assign expire = step && last;

  txg_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .cnt_o(cnt_w), .last_o(last)
  );

  txg_ctl ctl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .expire_i(expire),
    .mode_o(tx_mode_o), .flag_o(timeout_o), .entry_o(entry)
  );
endmodule

// File: rtl/txmode_guard_chk.sv
module txmode_guard_chk #(
  parameter int CNT_W  = 13,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hA2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 0,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 1,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              tx_mode_o,
  input logic              timeout_o,
  input logic [CNT_W-1:0]  cnt_i
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r4_tx_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mode_o |-> cnt_i != '0);

  a_r4_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mode_o && tick_i && !wr_en_i && cnt_i == ONE |=> !tx_mode_o && timeout_o);

  a_r5_rx_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_mode_o && !(wr_en_i && (wr_addr_i == MODE_ADDR || wr_addr_i == KICK_ADDR))
    |=> $stable(cnt_i) && !tx_mode_o);

  a_r6_kick_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == KICK_ADDR && wr_data_i == KEY
    |=> cnt_i == FULL && tx_mode_o == $past(tx_mode_o));

  a_r7_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == KICK_ADDR && wr_data_i != KEY && !tick_i
    |=> $stable(cnt_i) && $stable(tx_mode_o));

  a_r3_entry_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_mode_o && wr_en_i && wr_addr_i == MODE_ADDR && wr_data_i[0]
    |=> tx_mode_o && cnt_i == FULL);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !(wr_en_i && wr_addr_i == CLR_ADDR) |=> timeout_o);
endmodule

bind txmode_guard txmode_guard_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY),
  .MODE_ADDR(MODE_ADDR), .KICK_ADDR(KICK_ADDR), .CLR_ADDR(CLR_ADDR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .tx_mode_o(tx_mode_o),
  .timeout_o(timeout_o), .cnt_i(cnt_w)
);

// File: tb/txmode_guard_tb_top.sv
module txmode_guard_tb_top;
  localparam int CNT_W = 4;
  localparam int FULL  = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tx_mode, timeout;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  txmode_guard #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tx_mode_o(tx_mode), .timeout_o(timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with given inputs; outputs sampled 1 ns after the edge
  task automatic cyc(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 8'h00);
  endtask

  // ticks until mode drops, capped
  task automatic ticks_to_drop(output int n);
    n = 0;
    while (tx_mode && n < 3 * FULL) begin
      cyc(1'b1, 1'b0, 2'd0, 8'h00);
      n++;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    #20 rst_n = 1'b1;
    #1;
    check("R1 mode", tx_mode, 0);
    check("R1 flag", timeout, 0);

    // R5: ticks in receive do nothing
    ticks(2 * FULL);
    check("R5 mode", tx_mode, 0);
    check("R5 flag", timeout, 0);

    // R1/R4: full timeout from reset value
    cyc(1'b0, 1'b1, 2'd0, 8'h01);
    check("R2 enter", tx_mode, 1);
    ticks(FULL - 1);
    check("R4 before", tx_mode, 1);
    ticks(1);
    check("R4 drop", tx_mode, 0);
    check("R8 set", timeout, 1);
    cyc(1'b0, 1'b1, 2'd3, 8'h00);
    check("R8 other addr", timeout, 1);
    cyc(1'b0, 1'b1, 2'd2, 8'h00);
    check("R8 clear", timeout, 0);

    // R6: kick after every possible count
    for (int k = 1; k < FULL; k++) begin
      cyc(1'b0, 1'b1, 2'd0, 8'h01);
      ticks(k);
      cyc(1'b0, 1'b1, 2'd1, 8'hA2);
      check("R6 mode kept", tx_mode, 1);
      ticks_to_drop(n);
      check("R6 kick", n, FULL);
    end

    // R7: every byte at the key address
    for (int d = 0; d < 256; d++) begin
      cyc(1'b0, 1'b1, 2'd0, 8'h01);
      ticks(5);
      cyc(1'b0, 1'b1, 2'd1, 8'(d));
      ticks_to_drop(n);
      check(d == 8'hA2 ? "R6 key" : "R7 ignored", n, d == 8'hA2 ? FULL : FULL - 5);
    end
    cyc(1'b0, 1'b1, 2'd2, 8'h00);
    cyc(1'b0, 1'b1, 2'd1, 8'h55);
    check("R7 flag", timeout, 0);

    // R3: rewriting 1 in transmit does not reload
    cyc(1'b0, 1'b1, 2'd0, 8'h01);
    ticks(6);
    cyc(1'b0, 1'b1, 2'd0, 8'h03);
    ticks_to_drop(n);
    check("R3 no reload", n, FULL - 6);

    // R2/R3: leave then re-enter reloads
    cyc(1'b0, 1'b1, 2'd0, 8'h01);
    ticks(7);
    cyc(1'b0, 1'b1, 2'd0, 8'h02);
    check("R2 leave", tx_mode, 0);
    cyc(1'b0, 1'b1, 2'd0, 8'h01);
    ticks_to_drop(n);
    check("R3 reload", n, FULL);

    // R9: key with final tick
    cyc(1'b0, 1'b1, 2'd2, 8'h00);
    cyc(1'b0, 1'b1, 2'd0, 8'h01);
    ticks(FULL - 1);
    cyc(1'b1, 1'b1, 2'd1, 8'hA2);
    check("R9 saved", tx_mode, 1);
    check("R9 no flag", timeout, 0);
    ticks_to_drop(n);
    check("R9 full again", n, FULL);

    // R9: mode write with tick discards tick
    cyc(1'b0, 1'b1, 2'd0, 8'h01);
    ticks(3);
    cyc(1'b1, 1'b1, 2'd0, 8'h01);
    ticks_to_drop(n);
    check("R9 tick dropped", n, FULL - 3);

    // R8: clear coincides with expiry
    cyc(1'b0, 1'b1, 2'd2, 8'h00);
    check("R8 cleared", timeout, 0);
    cyc(1'b0, 1'b1, 2'd0, 8'h01);
    ticks(FULL - 1);
    cyc(1'b1, 1'b1, 2'd2, 8'h00);
    check("R8 set wins", timeout, 1);
    check("R4 forced", tx_mode, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule